// File: doc/BRIEF.md
# Powered-Port Load-Removal Delay Timer

This block decides, per port, when a powered port should be switched off because its load has disappeared. Each port has a delay counter. It advances on every millisecond tick during which the port current is below the disconnect threshold. When the counter reaches a programmable delay, the block emits a one-cycle disconnect pulse. Current measurement is outside the block: it receives a per-port below-threshold flag sampled by the caller.

The delay counter is not cleared by a single high sample. A separate qualification counter must see the current above the threshold for a run of consecutive ticks (nominally 15 ms) before the delay counter is wiped. Shorter bursts of high current freeze the delay count without clearing it. The timer runs only on ports that are powered and have load-removal detection enabled. Otherwise both counters stay at zero.

The 2-bit delay select is shared by all ports. Its encoding is not monotonic in the delay it selects.

Top module: `dcdisc_timer`

## Requirements
- R1: The delay select maps to a limit of below-threshold ticks: 2'b00 gives 4*DLY_UNIT, 2'b01 gives 1*DLY_UNIT, 2'b10 gives 2*DLY_UNIT and 2'b11 gives 8*DLY_UNIT. With the default DLY_UNIT of 90 these are 360, 90, 180 and 720 ms.
- R2: The delay counter advances only on a clock cycle where tick_ms is 1 and the port's below_thr bit is 1. Cycles without tick_ms never change it.
- R3: On the tick that brings the count to the limit, disc_evt for that port is 1 in the cycle after that clock edge and 0 in the next cycle. The count restarts from zero, so with below_thr held at 1 the pulses repeat every limit ticks.
- R4: When below_thr is 0 on QUAL_TICKS consecutive ticks, the delay count is cleared. A full limit of below-threshold ticks is then needed again.
- R5: A run of fewer than QUAL_TICKS above-threshold ticks holds the delay count: it neither advances nor clears.
- R6: Any tick with below_thr at 1 restarts the qualification run from zero. Interleaved short bursts therefore never clear the delay count.
- R7: While a port has powered at 0 or dis_en at 0, both of its counters are held at zero and its disc_evt stays 0. After the port is re-enabled, a full limit of ticks is counted afresh.
- R8: A change of dly_sel takes effect on the next tick. If the count already equals or exceeds the new limit, the next below-threshold tick trips the port.
- R9: Ports time independently of each other. A synchronous rst clears every counter and forces disc_evt to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond time base strobe |
| dly_sel | input | 2 | Shared delay select (encoding in R1) |
| below_thr | input | NPORTS | Per-port flag: current below the disconnect threshold |
| powered | input | NPORTS | Per-port flag: port is powered |
| dis_en | input | NPORTS | Per-port load-removal detection enable |
| disc_evt | output | NPORTS | Per-port one-cycle disconnect pulse |

## Verification
The bench builds the block with NPORTS=2, DLY_UNIT=3 and QUAL_TICKS=2. With these values the four limits are 12, 3, 6 and 24 ticks, and a qualifying high run is two ticks. Every delay select value, the hold-versus-clear boundary at one and two high ticks, and both directions of a select change mid-count can then be reached in a few hundred cycles. Expected trip positions are computed from the limit arithmetic. Port 1 is driven with contrasting inputs to show that the ports stay independent.

// File: rtl/dcdisc_pkg.sv
package dcdisc_pkg;

    typedef enum logic [1:0] {
        DLY_X4 = 2'b00,
        DLY_X1 = 2'b01,
        DLY_X2 = 2'b10,
        DLY_X8 = 2'b11
    } dly_sel_e;

    typedef struct packed {
        logic below;
        logic powered;
        logic enable;
    } port_in_t;

    localparam int unsigned MAX_MULT = 8;

    function automatic int unsigned sel_mult(dly_sel_e s);
        case (s)
            DLY_X1:  return 1;
            DLY_X2:  return 2;
            DLY_X4:  return 4;
            default: return MAX_MULT;
        endcase
    endfunction

endpackage

// File: rtl/dcdisc_qual.sv
module dcdisc_qual #(
    parameter int unsigned QUAL_TICKS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    input  logic above,
    output logic hit
);
    localparam int unsigned QW = $clog2(QUAL_TICKS + 1);
    localparam logic [QW-1:0] QMAX  = QW'(QUAL_TICKS);
    localparam logic [QW-1:0] QLAST = QW'(QUAL_TICKS - 1);

    logic [QW-1:0] run_q;

    assign hit = tick && above && !clear && (run_q >= QLAST);

    always_ff @(posedge clk) begin
        if (clear) begin
            run_q <= '0;
        end else if (tick) begin
            if (!above)
                run_q <= '0;
            else if (run_q != QMAX)
                run_q <= run_q + 1'b1;
        end
    end

    // R6
    qual_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !above && !clear) |=> (run_q == '0));

    // R7
    qual_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (run_q == '0));

endmodule

// File: rtl/dcdisc_delay.sv
module dcdisc_delay #(
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          tick,
    input  logic          below,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          fire
);
    logic [CW-1:0] cnt_q;
    logic [CW:0]   cnt_inc;
    logic          reach;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign reach   = cnt_inc >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt_q <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (tick) begin
                if (below) begin
                    if (reach) begin
                        cnt_q <= '0;
                        fire  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_inc[CW-1:0];
                    end
                end else if (restart) begin
                    cnt_q <= '0;
                end
            end
        end
    end

    // R2
    fire_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(tick && below));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(cnt_q));

    // R4
    qual_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !below && restart && !clear) |=> (cnt_q == '0));

    // R5
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !below && !restart && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/dcdisc_port.sv
module dcdisc_port
    import dcdisc_pkg::*;
#(
    parameter int unsigned QUAL_TICKS = 15,
    parameter int unsigned CW         = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  port_in_t      pin,
    input  logic [CW-1:0] limit,
    output logic          evt
);
    logic clear;
    logic qual_hit;

    assign clear = rst || !pin.powered || !pin.enable;

    dcdisc_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .tick  (tick),
        .above (!pin.below),
        .hit   (qual_hit)
    );

    dcdisc_delay #(.CW(CW)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .tick    (tick),
        .below   (pin.below),
        .restart (qual_hit),
        .limit   (limit),
        .fire    (evt)
    );

endmodule

// File: rtl/dcdisc_timer.sv
module dcdisc_timer
    import dcdisc_pkg::*;
#(
    parameter int unsigned NPORTS     = 4,
    parameter int unsigned DLY_UNIT   = 90,
    parameter int unsigned QUAL_TICKS = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_ms,
    input  logic [1:0]        dly_sel,
    input  logic [NPORTS-1:0] below_thr,
    input  logic [NPORTS-1:0] powered,
    input  logic [NPORTS-1:0] dis_en,
    output logic [NPORTS-1:0] disc_evt
);
    localparam int unsigned MAX_LIMIT = MAX_MULT * DLY_UNIT;
    localparam int unsigned CW        = $clog2(MAX_LIMIT + 1);

    logic [CW-1:0] limit;

    assign limit = CW'(sel_mult(dly_sel_e'(dly_sel)) * DLY_UNIT);

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        port_in_t pin;
        assign pin = '{below: below_thr[i], powered: powered[i], enable: dis_en[i]};

        dcdisc_port #(.QUAL_TICKS(QUAL_TICKS), .CW(CW)) u_port (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick_ms),
            .pin   (pin),
            .limit (limit),
            .evt   (disc_evt[i])
        );

        // R7
        gated_evt_chk: assert property (@(posedge clk) disable iff (rst)
            disc_evt[i] |-> $past(powered[i] && dis_en[i] && !rst));
    end

endmodule

// File: tb/dcdisc_timer_bench.sv
module dcdisc_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int UNIT = 3;
    localparam int QT = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          tick_ms;
    logic [1:0]    dly_sel;
    logic [NP-1:0] below_thr;
    logic [NP-1:0] powered;
    logic [NP-1:0] dis_en;
    logic [NP-1:0] disc_evt;

    int checks = 0;
    int failures = 0;
    int ticks_seen;
    int pulses;
    int first_at;
    int p1_pulses;
    int prev_evt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcdisc_timer #(.NPORTS(NP), .DLY_UNIT(UNIT), .QUAL_TICKS(QT)) u_dcdisc_timer (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .dly_sel(dly_sel),
        .below_thr(below_thr), .powered(powered), .dis_en(dis_en),
        .disc_evt(disc_evt)
    );

    function automatic int lim(int s);
        case (s)
            0: return 4 * UNIT;
            1: return UNIT;
            2: return 2 * UNIT;
            default: return 8 * UNIT;
        endcase
    endfunction

    task automatic chk(int act, int exp, string req);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic meas_start();
        ticks_seen = 0; pulses = 0; first_at = -1; p1_pulses = 0;
    endtask

    task automatic step(logic tk);
        @(negedge clk);
        tick_ms = tk;
        @(posedge clk);
        #1;
        if (tk) ticks_seen++;
        if (disc_evt[0]) begin
            pulses++;
            if (first_at < 0) first_at = ticks_seen;
        end
        if (disc_evt[1]) p1_pulses++;
        prev_evt = disc_evt[0];
    endtask

    task automatic run(int n, logic b0);
        below_thr[0] = b0;
        for (int k = 0; k < n; k++) step(1'b1);
    endtask

    task automatic wipe();
        dis_en = '0;
        step(1'b0);
        dis_en = '1;
        tick_ms = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; tick_ms = 1'b0; dly_sel = 2'b00;
        below_thr = '0; powered = '1; dis_en = '1;
        repeat (3) @(posedge clk);
        #1;
        chk(int'(disc_evt), 0, "R9 reset state");
        @(negedge clk);
        rst = 1'b0;

        // R1, R3: every select, continuous below, first and repeat pulses
        for (int s = 0; s < 4; s++) begin
            dly_sel = 2'(s);
            wipe();
            below_thr[1] = 1'b0;
            meas_start();
            run(lim(s), 1'b1);
            chk(first_at, lim(s), "R1 first trip position");
            step(1'b0);
            chk(prev_evt, 0, "R3 pulse lasts one cycle");
            run(2 * lim(s), 1'b1);
            chk(pulses, 3, "R3 repeat pulses every limit");
            chk(p1_pulses, 0, "R9 port1 idle above threshold");
        end

        // R2: cycles without tick do not count
        dly_sel = 2'b01;
        wipe();
        meas_start();
        below_thr[0] = 1'b1;
        for (int k = 0; k < 20; k++) step(1'b0);
        chk(pulses, 0, "R2 no count without tick");
        run(lim(1), 1'b1);
        chk(first_at, lim(1), "R2 trip after ticks only");

        // R5: single-tick bursts hold the count
        dly_sel = 2'b00;
        wipe();
        meas_start();
        run(5, 1'b1); run(QT - 1, 1'b0); run(lim(0) - 5, 1'b1);
        chk(first_at, lim(0) + QT - 1, "R5 short burst holds count");

        // R6: interleaved short bursts never qualify
        wipe();
        meas_start();
        run(4, 1'b1); run(1, 1'b0); run(1, 1'b1); run(1, 1'b0); run(lim(0) - 5, 1'b1);
        chk(first_at, lim(0) + 2, "R6 below tick restarts qualification");

        // R4: qualified run clears the count
        wipe();
        meas_start();
        run(lim(0) - 1, 1'b1); run(QT, 1'b0);
        chk(pulses, 0, "R4 no trip before clear");
        run(lim(0), 1'b1);
        chk(first_at, 2 * lim(0) - 1 + QT, "R4 full limit after clear");

        // R7: disabled and unpowered ports hold clear
        wipe();
        meas_start();
        dis_en[0] = 1'b0;
        run(3 * lim(0), 1'b1);
        chk(pulses, 0, "R7 disabled no pulse");
        dis_en[0] = 1'b1;
        meas_start();
        run(lim(0) - 2, 1'b1);
        powered[0] = 1'b0;
        run(2, 1'b1);
        powered[0] = 1'b1;
        meas_start();
        run(lim(0), 1'b1);
        chk(first_at, lim(0), "R7 count restarts after unpowered");

        // R8: select change mid-count
        wipe();
        meas_start();
        run(7, 1'b1);
        dly_sel = 2'b10;
        meas_start();
        run(1, 1'b1);
        chk(first_at, 1, "R8 shrink trips next tick");
        dly_sel = 2'b01;
        wipe();
        meas_start();
        run(2, 1'b1);
        dly_sel = 2'b11;
        run(lim(3), 1'b1);
        chk(first_at, lim(3), "R8 growth extends delay");

        // R9: ports independent
        dly_sel = 2'b01;
        wipe();
        meas_start();
        below_thr[1] = 1'b1;
        run(lim(1), 1'b0);
        chk(p1_pulses, 1, "R9 port1 trips alone");
        chk(pulses, 0, "R9 port0 unaffected");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule